// File: doc/BRIEF.md
# Context-Tagged Virtual Write-Through Cache

This block is a direct-mapped cache placed between a processor request port and a simple word-wide memory port. It is indexed and tagged by virtual address, and it stores data a whole line at a time. Each line's tag records four things: the address-space context that filled it, the page's writable and privileged rights at fill time, a valid flag and a 14-bit tag identifier. A lookup hits only when the line is valid, the identifier matches and the context matches. A hit that breaks the cached rights is answered with a protection fault instead of data.

Reads that miss fetch the whole 16-byte line as four word reads, then return the requested word. Every store goes to memory. A store that hits also merges its enabled bytes into the cached line. A store that misses leaves the cache untouched.

Software has three controls:
- a global enable; while it is low, every access goes straight to memory and no tag changes;
- a diagnostic port that reads and writes raw tag words by line number;
- a single-line flush.

After reset the block sweeps through the lines one per cycle to clear them, and accepts no requests until the sweep is done.

Top module: `ctx_vcache`

## Requirements
- R1: After reset, `cpu_busy` stays high for exactly LINES cycles while every valid flag is cleared, and `rsp_valid` stays low.
- R2: A read that hits (valid, address bits 29:16 equal the stored identifier, `cur_ctx` equals the stored context) responds on the next cycle with the cached word selected by address bits 3:2, and makes no memory access.
- R3: A read miss with the enable high makes four memory reads at the line's word addresses in ascending order, then returns the requested word. The line index is address bits 4 upward. The tag is written with the current context, `pg_wr`, `pg_priv`, valid=1 and address bits 29:16.
- R4: Every store that does not fault makes exactly one memory write with its byte enables. A store hit merges the enabled bytes into the cached line. A store miss allocates nothing, so a later read of that address misses.
- R5: A valid line whose identifier matches but whose stored context differs from `cur_ctx` is treated as a miss and is refilled.
- R6: With the enable high, a hit faults in two cases: a store to a line whose writable copy is 0, or an access with `cpu_user`=1 to a line whose privileged copy is 1. A faulting access responds the next cycle with `rsp_fault`=1, makes no memory access and changes no cached data.
- R7: While `cache_en` is low, a read makes a single memory read whose data is returned, a store makes a single memory write, and no tag word changes.
- R8: A diagnostic tag word has this layout: context in bits 24:22, writable in bit 21, privileged in bit 20, valid in bit 19, identifier in bits 15:2. All other bits read as 0 whatever was written. A written word takes effect for later lookups, and read data appears on `diag_rdata` one cycle after the request.
- R9: A flush request clears the valid flag of the indexed line only, in one cycle, so the next access to that line misses.
- R10: Flush, diagnostic and processor requests are taken only while `cpu_busy` is low. In the same cycle, flush wins over diagnostic, which wins over a processor request, and the losing request is dropped with no response.
- R11: Address bits 31:30 take no part in lookup or tagging. They are passed through unchanged on `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_en | input | 1 | Global cache enable |
| cur_ctx | input | 3 | Current address-space context |
| cpu_req | input | 1 | Processor request strobe |
| cpu_we | input | 1 | 1 = store, 0 = read |
| cpu_addr | input | 32 | Virtual byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_user | input | 1 | 1 = user-mode access |
| pg_wr | input | 1 | Page writable right |
| pg_priv | input | 1 | Page privileged-only right |
| cpu_busy | output | 1 | Requests are not taken while high |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | 32 | Read data (0 for stores and faults) |
| rsp_fault | output | 1 | Protection fault |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte enables |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| flush_req | input | 1 | Flush one line |
| flush_idx | input | IW | Line to flush |
| diag_req | input | 1 | Diagnostic tag access |
| diag_we | input | 1 | 1 = write tag word |
| diag_idx | input | IW | Line number for the tag access |
| diag_wdata | input | 32 | Tag word to write |
| diag_rdata | output | 32 | Tag word read |

## Verification
The bench switches context on a line that is already valid. A design that skipped the context compare would return the other space's data with no memory traffic, and the refill-count check catches that. It stores into lines filled read-only and reads privileged lines from user mode. A wrong fault rule either writes memory or returns data where a fault was due. It stores to an uncached address and then reads it back, which exposes a write-allocate. It accesses with bits 31:30 set, which exposes a tag compare that includes them. While the cache is disabled it checks through the diagnostic port that neither read nor store touched a tag. It fires a flush and a processor hit in the same cycle. A design with the wrong precedence would answer the hit, or leave the line valid.

// File: rtl/ctx_vcache.sv
module ctx_vcache #(
  parameter int LINES = 1024,
  localparam int IW = $clog2(LINES)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cache_en,
  input  logic [2:0]    cur_ctx,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [31:0]   cpu_addr,
  input  logic [31:0]   cpu_wdata,
  input  logic [3:0]    cpu_be,
  input  logic          cpu_user,
  input  logic          pg_wr,
  input  logic          pg_priv,
  output logic          cpu_busy,
  output logic          rsp_valid,
  output logic [31:0]   rsp_data,
  output logic          rsp_fault,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  input  logic          flush_req,
  input  logic [IW-1:0] flush_idx,
  input  logic          diag_req,
  input  logic          diag_we,
  input  logic [IW-1:0] diag_idx,
  input  logic [31:0]   diag_wdata,
  output logic [31:0]   diag_rdata
);
  typedef enum logic [2:0] {S_SWEEP, S_IDLE, S_FILL, S_WR, S_BYP} st_t;

  st_t              st;
  logic [18:0]      tg  [LINES];
  logic [127:0]     dat [LINES];
  logic [LINES-1:0] vld;
  logic [31:0]      a_q, d_q;
  logic [3:0]       be_q;
  logic [2:0]       ctx_q;
  logic             pw_q, pp_q;
  logic [1:0]       cnt;
  logic [95:0]      lb;
  logic [IW-1:0]    sw;

  function automatic logic [31:0] tword(input logic [18:0] e, input logic v);
    return {7'b0, e[18:16], e[15], e[14], v, 3'b0, e[13:0], 2'b0};
  endfunction

  logic [IW-1:0] idx, a_idx;
  logic [18:0]   ent;
  logic          hit, prot, acc;
  logic [127:0]  fline;
  logic [31:0]   hword, fword;

  assign idx   = cpu_addr[4 +: IW];
  assign a_idx = a_q[4 +: IW];
  assign ent   = tg[idx];
  assign hit   = cache_en & vld[idx] & (ent[13:0] == cpu_addr[29:16]) & (ent[18:16] == cur_ctx);
  assign prot  = hit & ((cpu_we & ~ent[15]) | (cpu_user & ent[14]));
  assign acc   = (st == S_IDLE) & cpu_req & ~flush_req & ~diag_req;
  assign fline = {mem_rdata, lb};
  assign hword = dat[idx][{cpu_addr[3:2], 5'b0} +: 32];
  assign fword = fline[{a_q[3:2], 5'b0} +: 32];

  assign cpu_busy  = (st != S_IDLE);
  assign mem_req   = (st == S_FILL) | (st == S_WR) | (st == S_BYP);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = (st == S_FILL) ? {a_q[31:4], cnt, 2'b00} : {a_q[31:2], 2'b00};
  assign mem_wdata = d_q;
  assign mem_be    = (st == S_WR) ? be_q : 4'hf;

  always_ff @(posedge clk) begin
    if (st == S_SWEEP) begin
      vld[sw] <= 1'b0;
    end else if (st == S_IDLE && flush_req) begin
      vld[flush_idx] <= 1'b0;
    end else if (st == S_IDLE && diag_req && diag_we) begin
      tg[diag_idx]  <= {diag_wdata[24:22], diag_wdata[21], diag_wdata[20], diag_wdata[15:2]};
      vld[diag_idx] <= diag_wdata[19];
    end else if (acc && cpu_we && hit && !prot) begin
      for (int b = 0; b < 4; b++)
        if (cpu_be[b]) dat[idx][{cpu_addr[3:2], b[1:0], 3'b0} +: 8] <= cpu_wdata[b*8 +: 8];
    end else if (st == S_FILL && mem_ack && cnt == 2'd3) begin
      dat[a_idx] <= fline;
      tg[a_idx]  <= {ctx_q, pw_q, pp_q, a_q[29:16]};
      vld[a_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_SWEEP;
      sw <= '0;
      cnt <= '0;
      lb <= '0;
      a_q <= '0;
      d_q <= '0;
      be_q <= '0;
      ctx_q <= '0;
      pw_q <= 1'b0;
      pp_q <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_data <= '0;
      diag_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_SWEEP: begin
          sw <= sw + 1'b1;
          if (sw == IW'(LINES - 1)) st <= S_IDLE;
        end
        S_IDLE: begin
          if (flush_req) begin
          end else if (diag_req) begin
            if (!diag_we) diag_rdata <= tword(tg[diag_idx], vld[diag_idx]);
          end else if (cpu_req) begin
            a_q   <= cpu_addr;
            d_q   <= cpu_wdata;
            be_q  <= cpu_be;
            ctx_q <= cur_ctx;
            pw_q  <= pg_wr;
            pp_q  <= pg_priv;
            cnt   <= '0;
            if (prot) begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b1;
              rsp_data  <= '0;
            end else if (cpu_we) begin
              st <= S_WR;
            end else if (hit) begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b0;
              rsp_data  <= hword;
            end else if (cache_en) begin
              st <= S_FILL;
            end else begin
              st <= S_BYP;
            end
          end
        end
        S_FILL: if (mem_ack) begin
          cnt <= cnt + 1'b1;
          lb  <= {mem_rdata, lb[95:32]};
          if (cnt == 2'd3) begin
            st <= S_IDLE;
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b0;
            rsp_data  <= fword;
          end
        end
        S_WR: if (mem_ack) begin
          st <= S_IDLE;
          rsp_valid <= 1'b1;
          rsp_fault <= 1'b0;
          rsp_data  <= '0;
        end
        S_BYP: if (mem_ack) begin
          st <= S_IDLE;
          rsp_valid <= 1'b1;
          rsp_fault <= 1'b0;
          rsp_data  <= mem_rdata;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module ctx_vcache_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cache_en,
  input logic        cpu_req,
  input logic        cpu_we,
  input logic        cpu_busy,
  input logic        flush_req,
  input logic        diag_req,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr
);
  logic taken;
  assign taken = cpu_req & ~cpu_busy & ~flush_req & ~diag_req;

  AST_FAULT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> !$past(mem_req)); // R6
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R3
  AST_RSP_AFTER_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_req); // R2
  AST_STORE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    taken && cpu_we |=> (mem_req && mem_we) || (rsp_valid && rsp_fault)); // R4
  AST_BYPASS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    taken && !cpu_we && !cache_en |=> mem_req && !mem_we); // R7
endmodule

bind ctx_vcache ctx_vcache_chk u_chk (.*);

// File: tb/test_ctx_vcache.sv
`timescale 1ns/1ps
module test_ctx_vcache;
  localparam int LINES = 16;
  localparam int IW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cache_en = 1'b1;
  logic [2:0] cur_ctx = 3'd1;
  logic cpu_req = 0, cpu_we = 0, cpu_user = 0, pg_wr = 0, pg_priv = 0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0] cpu_be = '0;
  logic cpu_busy, rsp_valid, rsp_fault;
  logic [31:0] rsp_data;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic flush_req = 0, diag_req = 0, diag_we = 0;
  logic [IW-1:0] flush_idx = '0, diag_idx = '0;
  logic [31:0] diag_wdata = '0, diag_rdata;

  ctx_vcache #(.LINES(LINES)) i_ctx_vcache (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, nrd = 0, nwr = 0, nrsp = 0;
  logic [31:0] mm [256];

  function automatic logic [7:0] mi(input logic [31:0] a);
    return {a[17:16], a[7:2]};
  endfunction
  function automatic logic [31:0] va(input logic [13:0] t, input logic [3:0] i, input logic [3:0] o);
    return {2'b00, t, 8'h00, i, o};
  endfunction
  function automatic logic [31:0] tw(input logic [2:0] c, input logic w, input logic p, input logic v, input logic [13:0] t);
    return {7'b0, c, w, p, v, 3'b0, t, 2'b0};
  endfunction

  initial for (int i = 0; i < 256; i++) mm[i] = 32'h5A000000 ^ (i * 32'h00010203);

  always_ff @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          nwr <= nwr + 1;
          for (int b = 0; b < 4; b++) if (mem_be[b]) mm[mi(mem_addr)][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        end else begin
          nrd <= nrd + 1;
          mem_rdata <= mm[mi(mem_addr)];
        end
      end
    end
  end

  logic [32:0] eq [$];
  logic        dq [$];
  string       rq [$];

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      nrsp++;
      checks++;
      if (eq.size() == 0) begin
        errors++;
        $display("FAIL R10: unexpected response got %h expected none", rsp_data);
      end else begin
        logic [32:0] e;
        logic d;
        string r;
        e = eq.pop_front(); d = dq.pop_front(); r = rq.pop_front();
        if (rsp_fault !== e[32] || (d && !e[32] && rsp_data !== e[31:0])) begin
          errors++;
          $display("FAIL %s: got fault=%b data=%h expected fault=%b data=%h", r, rsp_fault, rsp_data, e[32], e[31:0]);
        end
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (cpu_busy) @(negedge clk);
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd, input logic [3:0] be,
                        input logic usr, input logic pw, input logic pp, input logic xf, input string r);
    wait_idle();
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
    cpu_user = usr; pg_wr = pw; pg_priv = pp;
    eq.push_back({xf, mm[mi(a)]}); dq.push_back(!we); rq.push_back(r);
    @(negedge clk);
    cpu_req = 0;
    while (eq.size() > 0) @(negedge clk);
  endtask

  task automatic dg_read(input logic [IW-1:0] i, output logic [31:0] v);
    wait_idle();
    diag_req = 1; diag_we = 0; diag_idx = i;
    @(negedge clk);
    diag_req = 0;
    v = diag_rdata;
  endtask

  task automatic dg_write(input logic [IW-1:0] i, input logic [31:0] v);
    wait_idle();
    diag_req = 1; diag_we = 1; diag_idx = i; diag_wdata = v;
    @(negedge clk);
    diag_req = 0; diag_we = 0;
  endtask

  task automatic flush(input logic [IW-1:0] i);
    wait_idle();
    flush_req = 1; flush_idx = i;
    @(negedge clk);
    flush_req = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int n, r0, w0;
    logic [31:0] t, t6;
    repeat (3) @(negedge clk);
    rst_n = 1;
    n = 0;
    while (cpu_busy) begin n++; @(negedge clk); end
    chk("R1 sweep length", n, LINES);
    chk("R1 no response", {31'b0, rsp_valid}, 0);
    dg_read(3, t);
    chk("R1 valid cleared", {31'b0, t[19]}, 0);

    r0 = nrd;
    access(0, va(1, 3, 8), 0, 0, 0, 1, 0, 0, "R3 read miss data");
    chk("R3 four refill reads", nrd - r0, 4);
    dg_read(3, t);
    chk("R3 tag written", t, tw(1, 1, 0, 1, 1));

    r0 = nrd;
    access(0, va(1, 3, 4), 0, 0, 0, 1, 0, 0, "R2 read hit data");
    chk("R2 hit no memory", nrd - r0, 0);

    r0 = nrd;
    access(0, va(1, 3, 12) | 32'hC0000000, 0, 0, 0, 1, 0, 0, "R11 high bits data");
    chk("R11 high bits still hit", nrd - r0, 0);

    w0 = nwr;
    access(1, va(1, 3, 4), 32'h11223344, 4'b0101, 0, 1, 0, 0, "R4 store hit");
    chk("R4 store hit written through", nwr - w0, 1);
    r0 = nrd;
    access(0, va(1, 3, 4), 0, 0, 0, 1, 0, 0, "R4 merged bytes");
    chk("R4 merged read hits", nrd - r0, 0);

    w0 = nwr;
    access(1, va(2, 5, 0), 32'hCAFEF00D, 4'hf, 0, 1, 0, 0, "R4 store miss");
    chk("R4 store miss written", nwr - w0, 1);
    r0 = nrd;
    access(0, va(2, 5, 0), 0, 0, 0, 1, 0, 0, "R4 no allocate data");
    chk("R4 no allocate", nrd - r0, 4);

    cur_ctx = 3'd2;
    r0 = nrd;
    access(0, va(1, 3, 4), 0, 0, 0, 1, 0, 0, "R5 other context data");
    chk("R5 context mismatch misses", nrd - r0, 4);
    cur_ctx = 3'd1;
    r0 = nrd;
    access(0, va(1, 3, 4), 0, 0, 0, 1, 0, 0, "R5 back context data");
    chk("R5 switch back misses", nrd - r0, 4);

    access(0, va(1, 6, 0), 0, 0, 0, 0, 1, 0, "R6 fill protected line");
    w0 = nwr;
    access(1, va(1, 6, 0), 32'hDEADBEEF, 4'hf, 0, 0, 1, 1, "R6 store to read-only");
    chk("R6 fault no write", nwr - w0, 0);
    r0 = nrd;
    access(0, va(1, 6, 4), 0, 0, 1, 0, 1, 1, "R6 user on privileged");
    chk("R6 user fault no read", nrd - r0, 0);
    access(0, va(1, 6, 0), 0, 0, 0, 0, 1, 0, "R6 cache data unchanged");

    dg_read(6, t6);
    cache_en = 0;
    r0 = nrd;
    access(0, va(1, 6, 8), 0, 0, 1, 0, 1, 0, "R7 bypass read data");
    chk("R7 bypass single read", nrd - r0, 1);
    w0 = nwr;
    access(1, va(1, 9, 0), 32'h0BADCAFE, 4'hf, 0, 1, 0, 0, "R7 bypass store");
    chk("R7 bypass store written", nwr - w0, 1);
    access(0, va(1, 9, 0), 0, 0, 0, 1, 0, 0, "R7 bypass readback");
    dg_read(9, t);
    chk("R7 no tag allocated", {31'b0, t[19]}, 0);
    dg_read(6, t);
    chk("R7 tag unchanged", t, t6);
    cache_en = 1;

    flush(3);
    dg_read(3, t);
    chk("R9 flushed invalid", {31'b0, t[19]}, 0);
    dg_read(6, t);
    chk("R9 neighbour kept", {31'b0, t[19]}, 1);
    r0 = nrd;
    access(0, va(1, 3, 0), 0, 0, 0, 1, 0, 0, "R9 refill data");
    chk("R9 flushed line misses", nrd - r0, 4);

    dg_write(10, 32'hFFFFFFFF);
    dg_read(10, t);
    chk("R8 zero bits masked", t, 32'h01F8FFFC);
    access(0, va(5, 11, 0), 0, 0, 0, 1, 0, 0, "R8 fill line");
    flush(11);
    dg_write(11, tw(1, 1, 0, 1, 5));
    r0 = nrd;
    access(0, va(5, 11, 4), 0, 0, 0, 1, 0, 0, "R8 restored tag data");
    chk("R8 written tag hits", nrd - r0, 0);

    wait_idle();
    n = nrsp;
    flush_req = 1; flush_idx = 6;
    cpu_req = 1; cpu_we = 0; cpu_addr = va(1, 6, 0); cpu_user = 0;
    @(negedge clk);
    flush_req = 0; cpu_req = 0;
    repeat (4) @(negedge clk);
    chk("R10 dropped request", nrsp - n, 0);
    dg_read(6, t);
    chk("R10 flush won", {31'b0, t[19]}, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule